// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a simple SPI master. Each time a word is handed in on the transmit stream, it runs one full-duplex transfer of 1 to 32 bits on SCK, MOSI and MISO. When the transfer ends, the bits collected from MISO are offered on the receive stream. Four configuration inputs choose the transfer: the SCK level between transfers, which SCK edge samples MISO, the chip-select level, and the transfer length. An 8-bit divider sets the SCK rate.

Transmit words are left-justified: the first bit sent is bit 31. Receive words are right-justified: the last bit received lands in bit 0, and every bit above the transfer length is zero. Chip select is driven directly from its configuration bit and takes no part in the transfer sequencing. Mode, length and divider are captured when a word is accepted, so later changes to them act only on the next transfer.

Transmit back-pressure: `tx_ready` is high only while no transfer is running. A `tx_valid` that meets `tx_ready` low is dropped, not queued. A source that needs the word sent must hold it until `tx_ready` returns. Receive: `rx_valid` stays high until a cycle with `rx_ready` high, and that cycle consumes the word. The SPI side cannot be stalled, so a completion overwrites a word that has not been read.

Top module: `spi_shift_engine`

## Requirements
- R1: While no transfer runs, `sck` equals `cfg_idle` (0 gives idle low, 1 gives idle high). After a transfer ends, `sck` is back at that level.
- R2: With `cfg_edge`=0, MISO is sampled on rising SCK edges and MOSI changes only on falling edges. With `cfg_edge`=1, MISO is sampled on falling edges and MOSI changes only on rising edges. MOSI is stable at every sample edge.
- R3: `cs_n` is the inverse of `cfg_cs` at all times, including during a transfer.
- R4: `cfg_width` holds N-1. A transfer makes exactly 2N SCK toggles, of which N are sample edges. Value 31 gives 32 bits.
- R5: With divider D, each SCK half period lasts 2*D clock cycles. `rx_valid` rises 4*D*N cycles after the accepting edge. A divider of 0 acts as 1.
- R6: The transmit word is sent MSB first from bits [31:32-N]. Bits below 32-N are not sent.
- R7: `rx_data` returns the N received bits in [N-1:0], with the first received bit at N-1. Bits [31:N] are zero.
- R8: A transfer starts on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is low for the whole transfer. A `tx_valid` during a transfer changes neither the bits sent nor the timing, and starts nothing afterwards.
- R9: `rx_valid` goes high when a transfer completes and stays high with `rx_data` held until a cycle with `rx_ready` high, after which it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle | input | 1 | SCK level between transfers |
| cfg_edge | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_cs | input | 1 | 1 drives `cs_n` low |
| cfg_width | input | 5 | Transfer length minus one |
| divider | input | 8 | SCK rate divider, 0 treated as 1 |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine idle and able to take a word |
| tx_data | input | 32 | Left-justified transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumes the received word |
| rx_data | output | 32 | Right-justified received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The embedded properties assume three things about the inputs: reset is released cleanly, MISO carries a defined level whenever it is sampled, and the configuration is only worth checking against the value captured at acceptance. The bench uses a slave model that moves MISO only just after a sample edge, so MISO is always settled when it is sampled. It changes mode, length and divider only while the engine is idle, and touches chip select alone in mid-transfer. The sweep covers every length with all four mode combinations, plus several divider values including zero.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic {
    SAMPLE_RISE = 1'b0,
    SAMPLE_FALL = 1'b1
  } edge_e;

  typedef struct packed {
    logic  idle;
    edge_e edge_sel;
  } mode_t;

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_eff,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = {div_eff, 1'b0} - {{(CNT_W-1){1'b0}}, 1'b1};
  assign tick     = run && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: a half period is at least two cycles, so ticks never come back to back
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_next
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  assign mosi    = tx_sr[DATA_W-1];
  assign rx_next = sample_en ? {rx_sr[DATA_W-2:0], miso} : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
      rx_sr <= '0;
    end else begin
      if (shift_en) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      rx_sr <= rx_next;
    end
  end

  // R2: MOSI never moves on a sample edge
  a_r2_mosi_still_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !load) |=> $stable(mosi));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int TGL_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_idle,
  input  logic              cfg_edge,
  input  logic              cfg_cs,
  input  logic [LEN_W-1:0]  cfg_width,
  input  logic [DIV_W-1:0]  divider,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic              busy_q;
  logic              sck_q;
  logic              sampled_q;
  logic [TGL_W-1:0]  toggles_q;
  logic [LEN_W:0]    nbits_q;
  mode_t             mode_q;
  logic [DIV_W-1:0]  div_q;
  logic              rx_valid_q;
  logic [DATA_W-1:0] rx_data_q;

  logic              accept;
  logic              tick;
  logic              rising;
  logic              sample_en;
  logic              shift_en;
  logic              done;
  logic [LEN_W:0]    nbits;
  logic [DIV_W-1:0]  div_eff;
  logic [DATA_W-1:0] rx_next;

  assign tx_ready = !busy_q;
  assign accept   = tx_valid && !busy_q;
  assign nbits    = {1'b0, cfg_width} + {{LEN_W{1'b0}}, 1'b1};
  assign div_eff  = (divider == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : divider;

  // the coming toggle is rising when SCK is currently low
  assign rising    = !sck_q;
  assign sample_en = tick && (rising == (mode_q.edge_sel == SAMPLE_RISE));
  // a shift edge only advances data once a bit has been sampled
  assign shift_en  = tick && !sample_en && sampled_q;
  assign done      = tick && (toggles_q == {{(TGL_W-1){1'b0}}, 1'b1});

  spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .div_eff (div_q),
    .tick    (tick)
  );

  spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .tx_word   (tx_data),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sck_q     <= 1'b0;
      sampled_q <= 1'b0;
      toggles_q <= '0;
      nbits_q   <= '0;
      mode_q    <= '{idle: 1'b0, edge_sel: SAMPLE_RISE};
      div_q     <= '0;
    end else if (busy_q) begin
      if (tick) begin
        sck_q     <= ~sck_q;
        toggles_q <= toggles_q - 1'b1;
        if (sample_en) sampled_q <= 1'b1;
      end
      if (done) busy_q <= 1'b0;
    end else begin
      sck_q <= cfg_idle;
      if (accept) begin
        busy_q    <= 1'b1;
        sampled_q <= 1'b0;
        toggles_q <= {nbits, 1'b0};
        nbits_q   <= nbits;
        mode_q    <= '{idle: cfg_idle, edge_sel: edge_e'(cfg_edge)};
        div_q     <= div_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else if (done) begin
      rx_valid_q <= 1'b1;
      rx_data_q  <= rx_next;
    end else if (rx_ready) begin
      rx_valid_q <= 1'b0;
    end
  end

  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign sck      = sck_q;
  assign cs_n     = !cfg_cs;

  // R1: an even number of toggles brings SCK back to the captured idle level
  a_r1_sck_home: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sck == mode_q.idle));

  // R7: nothing above the transfer length is ever returned
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((rx_data >> nbits_q) == '0));

  // R8: an accepted word closes the transmit stream on the next cycle
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R9: completion raises the receive flag
  a_r9_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid);

  // R9: a read with no completion in the same cycle empties the receive side
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=> !rx_valid);

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_idle = 1'b0;
  logic        cfg_edge = 1'b0;
  logic        cfg_cs = 1'b0;
  logic [4:0]  cfg_width = 5'd0;
  logic [7:0]  divider = 8'd1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = 32'd0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic        sck;
  logic        mosi;
  logic        miso = 1'b0;
  logic        cs_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // slave model state
  bit          active = 1'b0;
  logic [31:0] slave_word = 32'd0;
  int          sidx = 0;
  logic [31:0] cap = 32'd0;
  int          samp_cnt = 0;
  int          tgl_cnt = 0;

  always #5 clk = ~clk;

  spi_shift_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_idle(cfg_idle), .cfg_edge(cfg_edge),
    .cfg_cs(cfg_cs), .cfg_width(cfg_width), .divider(divider),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // slave: capture MOSI on the sample edge, then present the next MISO bit
  always @(sck) begin
    if (active) begin
      tgl_cnt = tgl_cnt + 1;
      if ((sck === 1'b1) == (cfg_edge == 1'b0)) begin
        cap = {cap[30:0], mosi};
        samp_cnt = samp_cnt + 1;
        sidx = sidx - 1;
        miso = (sidx >= 0) ? slave_word[sidx] : 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit idl, input bit edg, input int n, input int dv,
                      input logic [31:0] txw, input logic [31:0] sw, input bit inject);
    int deff;
    int cycles;
    logic [31:0] mask;
    @(negedge clk);
    cfg_idle  = idl;
    cfg_edge  = edg;
    cfg_width = 5'(n - 1);
    divider   = 8'(dv);
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle sck", {31'd0, sck}, {31'd0, idl});
    deff = (dv == 0) ? 1 : dv;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    slave_word = sw & mask;
    sidx = n - 1;
    miso = slave_word[n-1];
    cap = 32'd0;
    samp_cnt = 0;
    tgl_cnt = 0;
    active = 1'b1;
    tx_data = txw;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    cycles = 0;
    while (!rx_valid && cycles < 20000) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (cycles == 1) chk("R8 ready low in transfer", {31'd0, tx_ready}, 32'd0);
      if (inject && cycles == 3) begin
        tx_data = ~txw;
        tx_valid = 1'b1;
      end else begin
        tx_valid = 1'b0;
      end
    end
    active = 1'b0;
    chk("R5 duration", cycles, 4 * deff * n);
    chk("R4 toggles", tgl_cnt, 2 * n);
    chk("R4 samples", samp_cnt, n);
    chk("R6 mosi bits", cap & mask, txw >> (32 - n));
    chk("R7 rx word", rx_data, sw & mask);
    chk("R1 sck home", {31'd0, sck}, {31'd0, idl});
    if (inject) begin
      repeat (12) @(negedge clk);
      chk("R8 no second transfer", {31'd0, tx_ready}, 32'd1);
      chk("R8 rx held", rx_data, sw & mask);
    end
    chk("R9 full held", {31'd0, rx_valid}, 32'd1);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R9 cleared by read", {31'd0, rx_valid}, 32'd0);
    chk("R9 data kept", rx_data, sw & mask);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1'b1;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset ready", {31'd0, tx_ready}, 32'd1);
    chk("R9 reset empty", {31'd0, rx_valid}, 32'd0);
    chk("R1 reset sck", {31'd0, sck}, 32'd0);
    chk("R3 reset cs", {31'd0, cs_n}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_cs = 1'b1;
    #1;
    chk("R3 cs asserted", {31'd0, cs_n}, 32'd0);
    cfg_cs = 1'b0;
    #1;
    chk("R3 cs released", {31'd0, cs_n}, 32'd1);

    // every length in all four modes
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 32; n++) begin
        xfer(m[0], m[1], n, 1, 32'hA5C3_0F96 ^ (32'(n) * 32'h0101_0101),
             {32'h3C5A_96E1} ^ (32'(n) << 7) ^ 32'(m), 1'b0);
      end
    end
    // divider values, including zero
    for (int d = 0; d < 4; d++) begin
      xfer(d[0], ~d[1], 8, d, 32'hD200_0000, 32'h0000_004B, 1'b0);
      xfer(~d[0], d[1], 32, d, 32'h8000_0001, 32'hF00F_1234, 1'b0);
    end
    xfer(1'b0, 1'b0, 13, 5, 32'h1234_5678, 32'h0000_1ABC, 1'b0);
    // writes offered mid-transfer are dropped
    xfer(1'b0, 1'b1, 16, 2, 32'hBEEF_0000, 32'h0000_C0DE, 1'b1);
    xfer(1'b1, 1'b0, 5, 3, 32'h9800_0000, 32'h0000_0015, 1'b1);

    // chip select stays under direct control during a transfer
    @(negedge clk);
    cfg_width = 5'd7;
    divider = 8'd4;
    cfg_edge = 1'b0;
    cfg_idle = 1'b0;
    tx_data = 32'h5500_0000;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    cfg_cs = 1'b1;
    #1;
    chk("R3 cs mid transfer", {31'd0, cs_n}, 32'd0);
    cfg_cs = 1'b0;
    #1;
    chk("R3 cs release mid transfer", {31'd0, cs_n}, 32'd1);
    while (!rx_valid) @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule